// File: doc/BRIEF.md
# Fuse-Programmable Registered Sum-of-Products Array

This block models a small field-programmable logic device. A 2048-bit fuse map is loaded serially and sets a programmable AND plane of 64 product terms over 16 array signals. Each signal enters the plane in both true and inverted form. The terms fall into eight fixed groups of eight, one group per output. Each group ends either in a D register or in a combinational output. A combinational output spends its first term on its own drive enable and takes the inverted OR of the remaining seven as its level.

A parameter sets how many outputs are registered: 0, 4, 6 or 8. The registered outputs sit in the middle of the output range. Register values and the received pad levels of the combinational pins feed back into the array, so the array can hold state machines. A test preload writes pad levels straight into the registers without going through the array. Each pin is modelled as a level bit plus a drive-enable bit. The surrounding logic resolves the pad and returns the received level on `pin_in`.

Top module: `pla_logic_array`

## Requirements
- R1: A synchronous active-high `rst` sets every register to 1. In the cycle after reset, every registered output shows `pin_val` = 0.
- R2: Until the fuse map is complete, every product term is false. Combinational outputs then show `pin_oe` = 0 and `pin_val` = 1. A clock edge without preload loads 0 into each register.
- R3: While `cfg_en` is high and the map is incomplete, each clock stores `cfg_bit` at fuse index N, where N is the number of bits already accepted. Fuses therefore fill in ascending order. Fuse index = row*32 + column. Column 2k is the true form of array signal k, and column 2k+1 is its inverse. Rows 8j to 8j+7 form the group of output j.
- R4: A fuse holding 1 includes its literal in the product term. A row with all 32 fuses at 1 is always false. A row with all fuses at 0 is always true.
- R5: Array signals 0 to 7 are `ded_in[7:0]`. Array signal 8+j is the feedback of output j: the register value for a registered output, `pin_in[j]` for a combinational one. With no registers, signals 8 and 15 come from `ded_in[8]` and `ded_in[9]`.
- R6: A registered output loads the OR of its eight terms on the rising clock edge. It shows `pin_val` = inverted register and `pin_oe` = NOT `oe_n`.
- R7: A combinational output j has `pin_oe` = row 8j and `pin_val` = NOR of rows 8j+1 to 8j+7.
- R8: The registered outputs are indices (8-NUM_REG)/2 through (8-NUM_REG)/2+NUM_REG-1. All other outputs are combinational.
- R9: With `preload` high and `rst` low at a clock edge, every register loads NOT `pin_in[j]`, so its `pin_val` then equals the applied level. The array is bypassed for the registers, and combinational outputs are unaffected.
- R10: After 2048 bits have been accepted, further `cfg_bit` values are ignored. The map stays complete until reset.
- R11: Reset restarts loading: the array stays inactive until 2048 new bits arrive. Reset takes priority over preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ded_in | input | 8 (10 when NUM_REG=0) | Dedicated array inputs |
| oe_n | input | 1 | Active-low drive enable shared by registered pins |
| preload | input | 1 | Loads registers from pad levels at the clock edge |
| pin_in | input | 8 | Received pad level of each output pin |
| pin_val | output | 8 | Level driven on each output pin |
| pin_oe | output | 8 | Drive enable of each output pin |
| cfg_en | input | 1 | Fuse shift enable |
| cfg_bit | input | 1 | Serial fuse data, lowest index first |

## Verification
The bench builds the array with NUM_REG=4, the default. This mix places combinational outputs at both ends and registers in the middle. One run therefore reaches both cell kinds, register feedback and pad feedback, and the boundary between outputs 1/2 and 5/6 where placement matters. The reference model takes the register count as a bench parameter, so the same model checks the 0, 6 and 8 variants when rebuilt.

// File: rtl/pla_pkg.sv
package pla_pkg;

    localparam int SIG_N     = 16;
    localparam int COL_N     = 2 * SIG_N;
    localparam int OUT_N     = 8;
    localparam int GRP_TERMS = 8;
    localparam int ROW_N     = OUT_N * GRP_TERMS;
    localparam int FUSE_N    = ROW_N * COL_N;
    localparam int IDX_W     = $clog2(FUSE_N);
    localparam int CNT_W     = $clog2(FUSE_N + 1);
    localparam int BASE_IN   = 8;

    typedef struct packed {
        logic drive;
        logic level;
    } pin_t;

    function automatic int first_reg(int nreg);
        return (OUT_N - nreg) / 2;
    endfunction

    function automatic bit is_reg(int nreg, int idx);
        return (idx >= first_reg(nreg)) && (idx < first_reg(nreg) + nreg);
    endfunction

    function automatic int ded_width(int nreg);
        return (nreg == 0) ? BASE_IN + 2 : BASE_IN;
    endfunction

    function automatic logic [OUT_N-1:0] reg_mask(int nreg);
        logic [OUT_N-1:0] m;
        for (int j = 0; j < OUT_N; j++) m[j] = is_reg(nreg, j);
        return m;
    endfunction

endpackage

// File: rtl/pla_fuse_store.sv
module pla_fuse_store
    import pla_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              load_bit,
    output logic [FUSE_N-1:0] fuse_map,
    output logic              map_ready
);

    logic [CNT_W-1:0] fill_cnt;
    logic             take;

    assign map_ready = (fill_cnt == CNT_W'(FUSE_N));
    assign take      = load_en && !map_ready;

    always_ff @(posedge clk) begin
        if (rst)       fill_cnt <= '0;
        else if (take) fill_cnt <= fill_cnt + 1'b1;
    end

    // Fuse cells are non-volatile in spirit: no reset on the storage.
    always_ff @(posedge clk) begin
        if (!rst && take) fuse_map[fill_cnt[IDX_W-1:0]] <= load_bit;
    end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
(
    input  logic [FUSE_N-1:0] fuse_map,
    input  logic              map_ready,
    input  logic [SIG_N-1:0]  sig,
    output logic [ROW_N-1:0]  term
);

    logic [COL_N-1:0] lit;

    always_comb begin
        for (int k = 0; k < SIG_N; k++) begin
            lit[2*k]     = sig[k];
            lit[2*k + 1] = ~sig[k];
        end
    end

    // A kept fuse (1) puts its literal into the product; a cleared fuse masks it.
    for (genvar r = 0; r < ROW_N; r++) begin : g_row
        assign term[r] = map_ready & (&(lit | ~fuse_map[r*COL_N +: COL_N]));
    end

endmodule

// File: rtl/pla_reg_cell.sv
module pla_reg_cell
    import pla_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 oe_n,
    input  logic                 preload,
    input  logic                 pad_in,
    input  logic [GRP_TERMS-1:0] terms,
    output pin_t                 pin,
    output logic                 fb
);

    logic state_q;

    always_ff @(posedge clk) begin
        if (rst)          state_q <= 1'b1;
        else if (preload) state_q <= ~pad_in;
        else              state_q <= |terms;
    end

    assign pin.level = ~state_q;
    assign pin.drive = ~oe_n;
    assign fb        = state_q;

endmodule

// File: rtl/pla_comb_cell.sv
module pla_comb_cell
    import pla_pkg::*;
(
    input  logic                 pad_in,
    input  logic [GRP_TERMS-1:0] terms,
    output pin_t                 pin,
    output logic                 fb
);

    assign pin.drive = terms[0];
    assign pin.level = ~(|terms[GRP_TERMS-1:1]);
    assign fb        = pad_in;

endmodule

// File: rtl/pla_logic_array.sv
module pla_logic_array
    import pla_pkg::*;
#(
    parameter int NUM_REG = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ded_width(NUM_REG)-1:0] ded_in,
    input  logic                          oe_n,
    input  logic                          preload,
    input  logic [OUT_N-1:0]              pin_in,
    output logic [OUT_N-1:0]              pin_val,
    output logic [OUT_N-1:0]              pin_oe,
    input  logic                          cfg_en,
    input  logic                          cfg_bit
);

    logic [FUSE_N-1:0] fuse_map;
    logic              map_ready;
    logic [SIG_N-1:0]  sig;
    logic [ROW_N-1:0]  term;
    logic [OUT_N-1:0]  fb;
    pin_t              pins [OUT_N];

    pla_fuse_store u_store (
        .clk       (clk),
        .rst       (rst),
        .load_en   (cfg_en),
        .load_bit  (cfg_bit),
        .fuse_map  (fuse_map),
        .map_ready (map_ready)
    );

    assign sig[BASE_IN-1:0] = ded_in[BASE_IN-1:0];

    for (genvar j = 0; j < OUT_N; j++) begin : g_sig
        if (NUM_REG == 0 && j == 0) begin : g_outer_lo
            assign sig[BASE_IN + j] = ded_in[BASE_IN];
        end else if (NUM_REG == 0 && j == OUT_N - 1) begin : g_outer_hi
            assign sig[BASE_IN + j] = ded_in[BASE_IN + 1];
        end else begin : g_fb
            assign sig[BASE_IN + j] = fb[j];
        end
    end

    pla_and_plane u_plane (
        .fuse_map  (fuse_map),
        .map_ready (map_ready),
        .sig       (sig),
        .term      (term)
    );

    for (genvar j = 0; j < OUT_N; j++) begin : g_out
        if (is_reg(NUM_REG, j)) begin : g_reg
            pla_reg_cell u_cell (
                .clk     (clk),
                .rst     (rst),
                .oe_n    (oe_n),
                .preload (preload),
                .pad_in  (pin_in[j]),
                .terms   (term[j*GRP_TERMS +: GRP_TERMS]),
                .pin     (pins[j]),
                .fb      (fb[j])
            );
        end else begin : g_comb
            pla_comb_cell u_cell (
                .pad_in (pin_in[j]),
                .terms  (term[j*GRP_TERMS +: GRP_TERMS]),
                .pin    (pins[j]),
                .fb     (fb[j])
            );
        end
        assign pin_val[j] = pins[j].level;
        assign pin_oe[j]  = pins[j].drive;
    end

endmodule

// File: rtl/pla_logic_array_chk.sv
module pla_logic_array_chk
    import pla_pkg::*;
#(
    parameter int NUM_REG = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             oe_n,
    input logic             preload,
    input logic [OUT_N-1:0] pin_in,
    input logic [OUT_N-1:0] pin_val,
    input logic [OUT_N-1:0] pin_oe,
    input logic             map_ready
);

    localparam logic [OUT_N-1:0] RM = reg_mask(NUM_REG);
    localparam logic [OUT_N-1:0] CM = ~RM;

    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen) begin
            p_reset_low_r1: assert ((pin_val & RM) == '0)
                else $error("registered pin high after reset");
            p_reset_unload_r11: assert (!map_ready)
                else $error("map ready right after reset");
        end
    end

    p_idle_comb_r2: assert property (@(posedge clk) disable iff (rst)
        !map_ready |-> ((pin_oe & CM) == '0) && ((pin_val & CM) == CM));

    p_idle_reg_r2: assert property (@(posedge clk) disable iff (rst)
        (!map_ready && !preload) |=> ((pin_val & RM) == RM));

    p_reg_drive_r6: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe & RM) == ({OUT_N{~oe_n}} & RM)));

    p_preload_r9: assert property (@(posedge clk) disable iff (rst)
        preload |=> ((pin_val & RM) == ($past(pin_in) & RM)));

    p_keep_loaded_r10: assert property (@(posedge clk) disable iff (rst)
        map_ready |=> map_ready);

endmodule

bind pla_logic_array pla_logic_array_chk #(.NUM_REG(NUM_REG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .oe_n      (oe_n),
    .preload   (preload),
    .pin_in    (pin_in),
    .pin_val   (pin_val),
    .pin_oe    (pin_oe),
    .map_ready (map_ready)
);

// File: tb/tb_pla_logic_array.sv
`timescale 1ns/1ps
module tb_pla_logic_array;
    import pla_pkg::*;

    localparam int P_REG = 4;
    localparam int DW    = ded_width(P_REG);

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] ded_in;
    logic          oe_n, preload, cfg_en, cfg_bit;
    logic [7:0]    pin_in;
    logic [7:0]    pin_val, pin_oe;

    always #10 clk = ~clk;

    pla_logic_array #(.NUM_REG(P_REG)) dut (
        .clk(clk), .rst(rst), .ded_in(ded_in), .oe_n(oe_n), .preload(preload),
        .pin_in(pin_in), .pin_val(pin_val), .pin_oe(pin_oe),
        .cfg_en(cfg_en), .cfg_bit(cfg_bit)
    );

    // Bench-side map to send and the model's own view of the device.
    bit       fmap  [2048];
    bit       mfuse [2048];
    int       mcnt;
    bit [7:0] mq;
    int       vectors = 0;
    int       errors  = 0;
    string    tag     = "R1";

    function automatic bit m_isreg(int j);
        int lo = (8 - P_REG) / 2;
        return (j >= lo) && (j < lo + P_REG);
    endfunction

    function automatic bit m_sig(int k);
        int j;
        if (k < 8) return ded_in[k];
        j = k - 8;
        if (P_REG == 0 && j == 0) return ded_in[DW-2];
        if (P_REG == 0 && j == 7) return ded_in[DW-1];
        if (m_isreg(j)) return mq[j];
        return pin_in[j];
    endfunction

    function automatic bit m_term(int r);
        if (mcnt < 2048) return 1'b0;
        for (int k = 0; k < 16; k++) begin
            bit t = m_sig(k);
            if (mfuse[r*32 + 2*k] && !t)    return 1'b0;
            if (mfuse[r*32 + 2*k + 1] && t) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit m_or(int first, int last);
        bit acc = 1'b0;
        for (int r = first; r <= last; r++) acc |= m_term(r);
        return acc;
    endfunction

    task automatic step();
        bit [7:0] ev, eo, nq;
        #2;
        for (int j = 0; j < 8; j++) begin
            if (m_isreg(j)) begin
                ev[j] = ~mq[j];
                eo[j] = ~oe_n;
            end else begin
                eo[j] = m_term(8*j);
                ev[j] = ~m_or(8*j + 1, 8*j + 7);
            end
        end
        vectors++;
        if (pin_val !== ev || pin_oe !== eo) begin
            errors++;
            $display("FAIL %s: pin_val=%h pin_oe=%h expected pin_val=%h pin_oe=%h",
                     tag, pin_val, pin_oe, ev, eo);
        end
        nq = mq;
        for (int j = 0; j < 8; j++)
            if (m_isreg(j)) nq[j] = preload ? ~pin_in[j] : m_or(8*j, 8*j + 7);
        @(posedge clk);
        if (rst) begin
            mq   = 8'hFF;
            mcnt = 0;
        end else begin
            mq = nq;
            if (cfg_en && mcnt < 2048) begin
                mfuse[mcnt] = cfg_bit;
                mcnt++;
            end
        end
        @(negedge clk);
    endtask

    task automatic rand_inputs();
        ded_in  = DW'($urandom);
        pin_in  = 8'($urandom);
        oe_n    = 1'($urandom_range(0, 1));
        preload = 1'b0;
        cfg_en  = 1'b0;
        cfg_bit = 1'($urandom);
        rst     = 1'b0;
    endtask

    // kind 0: sparse random literals; 1: all-kept / all-cleared rows; 2: placement probe
    task automatic make_map(int kind);
        for (int r = 0; r < 64; r++) begin
            for (int k = 0; k < 16; k++) begin
                int pick = $urandom_range(0, 7);
                bit t = (pick == 0);
                bit c = (pick == 1);
                if (kind == 1 && r % 3 == 0) begin t = 1; c = 1; end
                if (kind == 1 && r % 3 == 1) begin t = 0; c = 0; end
                if (kind == 2) begin t = (r % 8 != 0); c = t; end
                fmap[r*32 + 2*k]     = t;
                fmap[r*32 + 2*k + 1] = c;
            end
        end
    endtask

    task automatic load_map();
        tag = "R2";
        for (int i = 0; i < 2048; i++) begin
            rand_inputs();
            cfg_en  = 1'b1;
            cfg_bit = fmap[i];
            step();
        end
        cfg_en = 1'b0;
    endtask

    task automatic run(string t, int n, int pre_pct, bit extra_cfg);
        tag = t;
        for (int i = 0; i < n; i++) begin
            rand_inputs();
            preload = ($urandom_range(0, 99) < pre_pct);
            cfg_en  = extra_cfg;
            step();
        end
    endtask

    task automatic do_reset(string t);
        tag = t;
        rand_inputs();
        rst     = 1'b1;
        preload = 1'b1;        // R11: reset wins over preload
        step();
        step();
        rst     = 1'b0;
        preload = 1'b0;
        step();                // R1: registered pins read low here
    endtask

    initial begin
        #(20.0 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish (all requirements), got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        mq   = 8'hFF;
        mcnt = 0;
        rand_inputs();
        rst = 1'b1;
        @(negedge clk);
        do_reset("R1");
        run("R2", 20, 0, 1'b0);            // array inactive before any map
        run("R9", 20, 50, 1'b0);           // preload with inactive array

        make_map(0);
        load_map();
        run("R3", 300, 0, 1'b0);
        run("R5", 300, 0, 1'b0);           // feedback through registers and pads
        run("R6", 200, 0, 1'b0);
        run("R7", 200, 0, 1'b0);
        run("R10", 150, 0, 1'b1);          // extra bits must be ignored
        run("R9", 300, 30, 1'b0);

        do_reset("R11");
        run("R11", 30, 0, 1'b0);           // inactive again until reload
        make_map(1);
        load_map();
        run("R4", 200, 10, 1'b0);

        do_reset("R11");
        make_map(2);
        load_map();
        run("R8", 100, 0, 1'b0);

        do_reset("R1");
        make_map(0);
        load_map();
        run("R3", 400, 15, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule